// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single requests from an internal 16-bit memory port into cycles on an external bus. The external bus is multiplexed over two 8-bit pin ports, called A and B. Each external bus cycle lasts two clocks. In the first clock the bus phase clock E is low and the address is on the pins. In the second clock E is high and data moves. An external transparent latch, which is not part of this block, captures the address at the rising edge of E.

A strap input is sampled while reset is held, and it fixes one of two pin arrangements for as long as the block runs.
- **Wide mode:** the two ports carry the address first and then a full 16-bit data word.
- **Narrow mode:** both ports carry the address, and data passes through port A only, eight bits at a time. A 16-bit access in narrow mode therefore runs as two bus cycles, the high byte first.

A byte-sized request always uses a single bus cycle.

The requester raises `req_i` with the access attributes while the block is idle. It then waits for the one-clock `done_o` pulse. For a read, `rdata_o` is valid in the same clock as that pulse.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: `strap_wide_i` is captured on every clock while `rst_n` is low: 1 selects wide mode and 0 selects narrow mode. The captured mode holds until the next reset, and later changes of the strap have no effect.
- R2: While idle, `e_o` is 0, both output enables are 0 and `rw_o` is 1. A request sampled in idle starts a bus cycle on the next clock. Every bus cycle is one clock with `e_o`=0 (address phase) followed by one clock with `e_o`=1 (data phase).
- R3: Wide mode address phase: `pa_o`=addr[15:8] and `pb_o`=addr[7:0], with both ports driven. Throughout the access, `rw_o` is 1 for a read and 0 for a write.
- R4: Wide-mode word write, data phase: `pa_o`=wdata[15:8] and `pb_o`=wdata[7:0], both driven. Wide-mode word read result: `rdata_o`={port A, port B}.
- R5: Wide-mode byte access: addr[0]=0 selects port A and addr[0]=1 selects port B. A write drives wdata[7:0] on the selected port only. A read returns {8'h00, selected port}.
- R6: Narrow mode address phase: `pa_o`=addr[15:8] and `pb_o`=addr[7:0]. Port B stays driven with the low address byte through both phases of every cycle, reads included.
- R7: Narrow-mode word access: two consecutive bus cycles, the second at addr+1 (modulo 2^16). A write puts wdata[15:8] and then wdata[7:0] on port A. A read returns {first byte, second byte}.
- R8: Narrow-mode byte access: a single bus cycle. A write puts wdata[7:0] on port A. A read returns {8'h00, port A}.
- R9: On reads, port A (and, in wide mode, port B) is released during the data phase. The pins are sampled at the clock edge that ends the data phase.
- R10: `done_o` is high for exactly one clock, the clock after the last data phase. Reads and writes both produce it, and `rdata_o` holds the read result from that clock on.
- R11: A request raised while a transfer is in progress is ignored. A request presented in the `done_o` clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the mode strap is captured while it is low |
| strap_wide_i | input | 1 | Mode strap: 1 wide, 0 narrow |
| req_i | input | 1 | Request, sampled only when idle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_word_i | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 16 | Write data; a byte write uses bits 7:0 |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read result |
| e_o | output | 1 | Bus phase clock E |
| rw_o | output | 1 | 1 read, 0 write |
| pa_o | output | 8 | Port A output value |
| pa_oe_o | output | 1 | Port A drive enable |
| pa_i | input | 8 | Port A pin value |
| pb_o | output | 8 | Port B output value |
| pb_oe_o | output | 1 | Port B drive enable |
| pb_i | input | 8 | Port B pin value |

## Verification
The completion pulse of one transfer and the acceptance of the next request can fall in the same clock. The bench provokes this by presenting a new request in the very clock in which `done_o` is high. It judges the result by finding `rdata_o` correct in that clock and by seeing the next address phase begin one clock later, with no idle gap. A second collision is a request raised while a narrow word transfer is between its two byte cycles, or during any address or data phase. In that case the bench checks that the pins still show the original transfer, and that the bus is idle in the clock after completion.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    parameter int unsigned PORT_W = 8;
    localparam int unsigned BUS_W = 2 * PORT_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic               wr;
        logic               word;
        logic               second;
        logic [BUS_W-1:0]   addr;
        logic [BUS_W-1:0]   wdata;
        logic [PORT_W-1:0]  hi_byte;
        logic [BUS_W-1:0]   rdata;
        logic               done;
    } seq_t;
endpackage

// File: rtl/xbus_strap.sv
module xbus_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic wide_o
);
    logic wide_d, wide_q;

    always_comb begin
        wide_d = wide_q;
        if (!rst_n) wide_d = strap_i;
    end

    always_ff @(posedge clk) begin
        wide_q <= wide_d;
    end

    assign wide_o = wide_q;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic              req_word_i,
    input  logic [BUS_W-1:0]  req_addr_i,
    input  logic [BUS_W-1:0]  req_wdata_i,
    input  logic [PORT_W-1:0] pa_i,
    input  logic [PORT_W-1:0] pb_i,
    output phase_e            ph_o,
    output logic              wr_o,
    output logic              word_o,
    output logic              second_o,
    output logic [BUS_W-1:0]  addr_o,
    output logic [BUS_W-1:0]  wdata_o,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              done_o
);
    localparam logic [BUS_W-1:0] ADDR_STEP = BUS_W'(1);
    localparam logic [PORT_W-1:0] ZERO_BYTE = '0;

    seq_t s_d, s_q;
    logic split_more;
    logic [BUS_W-1:0] rd_word;

    // narrow word access still has its low byte cycle to run
    assign split_more = !wide_i && s_q.word && !s_q.second;

    always_comb begin
        if (wide_i) begin
            if (s_q.word)         rd_word = {pa_i, pb_i};
            else if (s_q.addr[0]) rd_word = {ZERO_BYTE, pb_i};
            else                  rd_word = {ZERO_BYTE, pa_i};
        end else begin
            if (s_q.word)         rd_word = {s_q.hi_byte, pa_i};
            else                  rd_word = {ZERO_BYTE, pa_i};
        end
    end

    always_comb begin
        s_d = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    s_d.ph     = PH_ADDR;
                    s_d.wr     = req_write_i;
                    s_d.word   = req_word_i;
                    s_d.second = 1'b0;
                    s_d.addr   = req_addr_i;
                    s_d.wdata  = req_wdata_i;
                end
            end
            PH_ADDR: s_d.ph = PH_DATA;
            PH_DATA: begin
                if (split_more) begin
                    s_d.ph     = PH_ADDR;
                    s_d.second = 1'b1;
                    s_d.addr   = s_q.addr + ADDR_STEP;
                    if (!s_q.wr) s_d.hi_byte = pa_i;
                end else begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    if (!s_q.wr) s_d.rdata = rd_word;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ph_o     = s_q.ph;
    assign wr_o     = s_q.wr;
    assign word_o   = s_q.word;
    assign second_o = s_q.second;
    assign addr_o   = s_q.addr;
    assign wdata_o  = s_q.wdata;
    assign rdata_o  = s_q.rdata;
    assign done_o   = s_q.done;
endmodule

// File: rtl/xbus_pindrv.sv
module xbus_pindrv
    import xbus_pkg::*;
(
    input  phase_e            ph_i,
    input  logic              wide_i,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic              second_i,
    input  logic [BUS_W-1:0]  addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic              e_o,
    output logic              rw_o,
    output logic [PORT_W-1:0] pa_o,
    output logic              pa_oe_o,
    output logic [PORT_W-1:0] pb_o,
    output logic              pb_oe_o
);
    logic [PORT_W-1:0] a_hi, a_lo, d_hi, d_lo;

    assign a_hi = addr_i[BUS_W-1:PORT_W];
    assign a_lo = addr_i[PORT_W-1:0];
    assign d_hi = wdata_i[BUS_W-1:PORT_W];
    assign d_lo = wdata_i[PORT_W-1:0];

    always_comb begin
        e_o     = 1'b0;
        rw_o    = 1'b1;
        pa_o    = '0;
        pb_o    = '0;
        pa_oe_o = 1'b0;
        pb_oe_o = 1'b0;
        unique case (ph_i)
            PH_ADDR: begin
                rw_o    = !wr_i;
                pa_o    = a_hi;
                pb_o    = a_lo;
                pa_oe_o = 1'b1;
                pb_oe_o = 1'b1;
            end
            PH_DATA: begin
                e_o  = 1'b1;
                rw_o = !wr_i;
                if (wide_i) begin
                    if (word_i) begin
                        pa_o    = d_hi;
                        pb_o    = d_lo;
                        pa_oe_o = wr_i;
                        pb_oe_o = wr_i;
                    end else begin
                        pa_o    = d_lo;
                        pb_o    = d_lo;
                        pa_oe_o = wr_i && !addr_i[0];
                        pb_oe_o = wr_i && addr_i[0];
                    end
                end else begin
                    pb_o    = a_lo;
                    pb_oe_o = 1'b1;
                    pa_o    = (word_i && !second_i) ? d_hi : d_lo;
                    pa_oe_o = wr_i;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xbus_mux_ctrl.sv
module xbus_mux_ctrl
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_wide_i,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic              req_word_i,
    input  logic [BUS_W-1:0]  req_addr_i,
    input  logic [BUS_W-1:0]  req_wdata_i,
    output logic              done_o,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              e_o,
    output logic              rw_o,
    output logic [PORT_W-1:0] pa_o,
    output logic              pa_oe_o,
    input  logic [PORT_W-1:0] pa_i,
    output logic [PORT_W-1:0] pb_o,
    output logic              pb_oe_o,
    input  logic [PORT_W-1:0] pb_i
);
    logic             mode_wide;
    phase_e           ph;
    logic             wr, word, second;
    logic [BUS_W-1:0] addr, wdata;

    xbus_strap u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_wide_i),
        .wide_o  (mode_wide)
    );

    xbus_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_i      (mode_wide),
        .req_i       (req_i),
        .req_write_i (req_write_i),
        .req_word_i  (req_word_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .pa_i        (pa_i),
        .pb_i        (pb_i),
        .ph_o        (ph),
        .wr_o        (wr),
        .word_o      (word),
        .second_o    (second),
        .addr_o      (addr),
        .wdata_o     (wdata),
        .rdata_o     (rdata_o),
        .done_o      (done_o)
    );

    xbus_pindrv u_pins (
        .ph_i     (ph),
        .wide_i   (mode_wide),
        .wr_i     (wr),
        .word_i   (word),
        .second_i (second),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .e_o      (e_o),
        .rw_o     (rw_o),
        .pa_o     (pa_o),
        .pa_oe_o  (pa_oe_o),
        .pb_o     (pb_o),
        .pb_oe_o  (pb_oe_o)
    );
endmodule

// File: rtl/xbus_mux_ctrl_chk.sv
module xbus_mux_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_wide,
    input logic e_o,
    input logic rw_o,
    input logic pa_oe_o,
    input logic pb_oe_o,
    input logic done_o
);
    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_wide));

    // R2
    e_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_o |=> !e_o);

    // R2
    e_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_o |-> $past(!e_o && pa_oe_o && pb_oe_o));

    // R9
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_o && rw_o) |-> !pa_oe_o);

    // R6
    nb_low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wide && e_o) |-> pb_oe_o);

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_o && !rw_o) |-> (pa_oe_o || pb_oe_o));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(e_o) && !e_o));
endmodule

bind xbus_mux_ctrl xbus_mux_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wide (mode_wide),
    .e_o       (e_o),
    .rw_o      (rw_o),
    .pa_oe_o   (pa_oe_o),
    .pb_oe_o   (pb_oe_o),
    .done_o    (done_o)
);

// File: tb/xbus_mux_ctrl_tb.sv
module xbus_mux_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_wide_i = 1'b1;
    logic        req_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic        req_word_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        done_o;
    logic [15:0] rdata_o;
    logic        e_o, rw_o, pa_oe_o, pb_oe_o;
    logic [7:0]  pa_o, pb_o, pa_i, pb_i;

    int n_chk = 0;
    int n_fail = 0;
    bit wide_mode = 1'b1;
    bit finished = 1'b0;
    logic [15:0] lat = '0;
    logic [16:0] exp_q[$];

    always #10 clk = ~clk;

    xbus_mux_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .strap_wide_i(strap_wide_i),
        .req_i(req_i), .req_write_i(req_write_i), .req_word_i(req_word_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .done_o(done_o), .rdata_o(rdata_o), .e_o(e_o), .rw_o(rw_o),
        .pa_o(pa_o), .pa_oe_o(pa_oe_o), .pa_i(pa_i),
        .pb_o(pb_o), .pb_oe_o(pb_oe_o), .pb_i(pb_i)
    );

    function automatic logic [7:0] byte_at(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    // external memory model: latch address in the address phase
    always @(negedge clk) if (!e_o && pb_oe_o) lat <= {pa_o, pb_o};
    always_comb begin
        if (wide_mode) begin
            pa_i = byte_at({lat[15:1], 1'b0});
            pb_i = byte_at({lat[15:1], 1'b1});
        end else begin
            pa_i = byte_at(lat);
            pb_i = 8'hEE;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", 32'd1, 32'd0);
            end else begin
                logic [16:0] it;
                it = exp_q.pop_front();
                if (it[16]) chk(rdata_o == it[15:0], "R4 R5 R7 R8 read data", rdata_o, it[15:0]);
            end
        end
    end

    function automatic logic [15:0] exp_read(input logic word, input logic [15:0] a);
        if (wide_mode) begin
            if (word) return {byte_at({a[15:1], 1'b0}), byte_at({a[15:1], 1'b1})};
            return {8'h00, byte_at(a)};
        end
        if (word) return {byte_at(a), byte_at(a + 16'd1)};
        return {8'h00, byte_at(a)};
    endfunction

    task automatic do_xfer(input logic w, input logic word, input logic [15:0] a,
                           input logic [15:0] wd, input bit poke);
        int ncyc;
        ncyc = (!wide_mode && word) ? 2 : 1;
        req_i = 1'b1; req_write_i = w; req_word_i = word;
        req_addr_i = a; req_wdata_i = wd;
        exp_q.push_back({!w, w ? 16'h0 : exp_read(word, a)});
        @(negedge clk);
        req_i = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            logic [15:0] ac;
            ac = a + 16'(c);
            chk(e_o == 1'b0, "R2 addr phase E", e_o, 0);
            chk(rw_o == !w, "R3 rw", rw_o, !w);
            chk({pa_o, pb_o} == ac && pa_oe_o && pb_oe_o,
                wide_mode ? "R3 address" : "R6 R7 address", {pa_oe_o, pb_oe_o, pa_o, pb_o}, {2'b11, ac});
            if (poke) begin
                req_i = 1'b1; req_write_i = !w; req_addr_i = a ^ 16'h0F0F; req_wdata_i = ~wd;
            end
            @(negedge clk);
            chk(e_o == 1'b1, "R2 data phase E", e_o, 1);
            if (wide_mode) begin
                if (w && word)
                    chk({pa_oe_o, pb_oe_o, pa_o, pb_o} == {2'b11, wd}, "R4 word write", {pa_oe_o, pb_oe_o, pa_o, pb_o}, {2'b11, wd});
                else if (w)
                    chk({pa_oe_o, pb_oe_o} == {!a[0], a[0]} && (a[0] ? pb_o : pa_o) == wd[7:0],
                        "R5 byte write", {pa_oe_o, pb_oe_o, a[0] ? pb_o : pa_o}, {!a[0], a[0], wd[7:0]});
                else
                    chk(!pa_oe_o && !pb_oe_o, "R9 wide release", {pa_oe_o, pb_oe_o}, 0);
            end else begin
                chk(pb_oe_o && pb_o == ac[7:0], "R6 port B hold", {pb_oe_o, pb_o}, {1'b1, ac[7:0]});
                if (w) begin
                    logic [7:0] eb;
                    eb = (word && c == 0) ? wd[15:8] : wd[7:0];
                    chk(pa_oe_o && pa_o == eb, word ? "R7 byte order" : "R8 byte write", {pa_oe_o, pa_o}, {1'b1, eb});
                end else begin
                    chk(!pa_oe_o, "R9 narrow release", pa_oe_o, 0);
                end
            end
            @(negedge clk);
        end
        req_i = 1'b0;
        chk(done_o == 1'b1 && e_o == 1'b0, "R10 done timing", {done_o, e_o}, 2'b10);
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk({done_o, e_o, pa_oe_o, pb_oe_o, rw_o} == 5'b00001, req, {done_o, e_o, pa_oe_o, pb_oe_o, rw_o}, 5'b00001);
    endtask

    task automatic do_reset(input bit wide);
        rst_n = 1'b0;
        strap_wide_i = wide;
        wide_mode = wide;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk({done_o, e_o, pa_oe_o, pb_oe_o, rw_o} == 5'b00001, "R2 reset idle",
            {done_o, e_o, pa_oe_o, pb_oe_o, rw_o}, 5'b00001);
        strap_wide_i = !wide;  // R1: must be ignored from here on
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // wide mode
        do_reset(1'b1);
        do_xfer(1'b1, 1'b1, 16'h1234, 16'hBEEF, 1'b0); idle_chk("R10 single done");
        // R1: a narrow-mode device would keep port B driven in this data phase
        do_xfer(1'b0, 1'b1, 16'h2000, 16'h0, 1'b0);    idle_chk("R1 mode held");
        do_xfer(1'b1, 1'b0, 16'h3000, 16'h00A5, 1'b0); idle_chk("R5 even");
        do_xfer(1'b1, 1'b0, 16'h3001, 16'h005A, 1'b0); idle_chk("R5 odd");
        do_xfer(1'b0, 1'b0, 16'h4002, 16'h0, 1'b0);    idle_chk("R5 read even");
        do_xfer(1'b0, 1'b0, 16'h4003, 16'h0, 1'b0);    idle_chk("R5 read odd");
        do_xfer(1'b0, 1'b1, 16'h5554, 16'h1111, 1'b1); idle_chk("R11 busy ignored wide");
        // R11 back-to-back: next request in the done clock
        do_xfer(1'b0, 1'b1, 16'h0A0A, 16'h0, 1'b0);
        do_xfer(1'b1, 1'b1, 16'h0B0C, 16'h7E81, 1'b0); idle_chk("R11 back-to-back wide");
        // narrow mode
        do_reset(1'b0);
        do_xfer(1'b1, 1'b1, 16'h5678, 16'hCAFE, 1'b0); idle_chk("R7 narrow write");
        do_xfer(1'b0, 1'b1, 16'h6001, 16'h0, 1'b0);    idle_chk("R7 narrow read");
        do_xfer(1'b0, 1'b1, 16'hFFFF, 16'h0, 1'b0);    idle_chk("R7 wrap");
        do_xfer(1'b1, 1'b0, 16'h7000, 16'h0042, 1'b0); idle_chk("R8 byte write");
        do_xfer(1'b0, 1'b0, 16'h7005, 16'h0, 1'b0);    idle_chk("R8 byte read");
        do_xfer(1'b1, 1'b1, 16'h1357, 16'h2468, 1'b1); idle_chk("R11 busy ignored narrow");
        do_xfer(1'b0, 1'b1, 16'h8080, 16'h0, 1'b0);
        do_xfer(1'b1, 1'b0, 16'h9091, 16'h00C3, 1'b0); idle_chk("R11 back-to-back narrow");
        chk(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule